// File: doc/BRIEF.md
# Configurable Logic Cluster

This block is a synthesizable soft model of one programmable logic tile. It contains ten logic elements. Each element is a six-input lookup table followed by a D flip-flop, and a per-element mode bit decides whether the element output is the flip-flop or the raw table value. A complete local crossbar feeds all sixty table pins. Each pin can take any of the forty cluster inputs, any of the ten element outputs fed back into the tile, or a constant zero. Cluster output i is element i's output.

All programming data sits in one serial chain of 1010 bits: the truth tables, the crossbar select codes and the mode bits. It is loaded through `cfg_in` while `cfg_en` is high. The chain is not touched by reset. While the chain shifts, the cluster outputs read zero and the flip-flops are cleared, so every freshly loaded function starts from a known state. Chains of combinational elements linked through the feedback paths resolve within the same clock cycle. A feedback loop must pass through at least one registered element.

Top module: `logic_cluster`

## Requirements
- R1: The chain holds 1010 bits. On each clock with `cfg_en` high, `cfg_in` enters at the top and every bit moves one place toward position 0. After 1010 shifts, the first bit shifted in sits at position 0. `cfg_out` always shows position 0. With `cfg_en` low the chain does not move.
- R2: Element e's truth table occupies chain positions 64e to 64e+63. The table output is the bit whose index is the sum over pins p of (pin value × 2^p).
- R3: The select code for element e, pin p is the 6-bit field at position 640+36e+6p, least significant bit lowest. Codes 0 to 39 pick `clu_in[code]`, codes 40 to 49 pick element output code−40, and codes 50 to 63 give 0.
- R4: Position 1000+e is element e's mode bit. With a 1, the element output is its flip-flop, which holds the table value from the previous clock edge. With a 0, the output is the table value in the same cycle.
- R5: `clu_out[i]` is element i's output. Every element's flip-flop captures that element's table value on each clock edge, whatever its mode.
- R6: While `cfg_en` is high, `clu_out` is all zero and every flip-flop is cleared at each clock edge.
- R7: `rst` is synchronous and active high. It clears every flip-flop and leaves the chain contents and the loaded functions unchanged.
- R8: Purely combinational chains through the feedback paths, up to all ten elements deep and in any index order, settle within the same cycle.
- R9: Loops closed through registered elements, such as a counter, advance exactly one step per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cluster clock for the flip-flops and the chain |
| rst | input | 1 | Synchronous active-high clear of the flip-flops |
| cfg_en | input | 1 | Shift enable for the programming chain |
| cfg_in | input | 1 | Serial programming data |
| cfg_out | output | 1 | Chain bit at position 0 |
| clu_in | input | 40 | Cluster inputs available to the crossbar |
| clu_out | output | 10 | Element outputs |

## Verification
Each result is due at a different point:
- Combinational elements, including ten-deep feedback chains, must be correct in the same cycle as the input change.
- Registered elements show the table value captured at the clock edge before.
- A reset or a load shows its effect on the flip-flops from the first cycle after it.
- During a load, bit k of the old image must be on `cfg_out` before the k-th shift edge.

The bench changes inputs on the falling edge and samples 1 ns later, well before the next rising edge. It compares against an interpreter of the loaded image that it steps at each rising edge, so each register delay is counted exactly once.

// File: rtl/cluster_pkg.sv
`timescale 1ns/1ps
package cluster_pkg;
    // default geometry of one tile
    localparam int unsigned CL_ELEMS  = 10;
    localparam int unsigned CL_LUT_K  = 6;
    localparam int unsigned CL_INPUTS = 40;
    localparam int unsigned CL_SEL_W  = 6;
endpackage

// File: rtl/cluster_cfg_chain.sv
`timescale 1ns/1ps
module cluster_cfg_chain #(
    parameter int unsigned LEN = 1010
) (
    input  logic           clk,
    input  logic           cfg_en,
    input  logic           cfg_in,
    output logic           cfg_out,
    output logic [LEN-1:0] cfg_bits
);
    typedef struct packed {
        logic [LEN-1:0] bits;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (cfg_en) begin
            chain_d.bits = {cfg_in, chain_q.bits[LEN-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    assign cfg_bits = chain_q.bits;
    assign cfg_out  = chain_q.bits[0];
endmodule

// File: rtl/cluster_pass.sv
`timescale 1ns/1ps
// One evaluation pass: crossbar selection and table lookup for every element,
// using a given view of the element outputs as feedback sources.
module cluster_pass #(
    parameter int unsigned N_ELEM = 10,
    parameter int unsigned K      = 6,
    parameter int unsigned N_IN   = 40,
    parameter int unsigned SEL_W  = 6
) (
    input  logic [N_IN-1:0]               clu_in,
    input  logic [N_ELEM-1:0]             fb,
    input  logic [N_ELEM*(1<<K)-1:0]      tables,
    input  logic [N_ELEM*K*SEL_W-1:0]     sels,
    output logic [N_ELEM-1:0]             lut_o
);
    localparam int unsigned LUT_SZ = 1 << K;

    logic [K-1:0]      addr [N_ELEM];
    logic [LUT_SZ-1:0] row  [N_ELEM];

    function automatic logic pick_src(input logic [SEL_W-1:0] code,
                                      input logic [N_IN-1:0]  pins,
                                      input logic [N_ELEM-1:0] fbv);
        logic v;
        v = 1'b0;
        for (int s = 0; s < int'(N_IN); s++) begin
            if (code == SEL_W'(s)) v = pins[s];
        end
        for (int s = 0; s < int'(N_ELEM); s++) begin
            if (code == SEL_W'(int'(N_IN) + s)) v = fbv[s];
        end
        return v;
    endfunction

    always_comb begin
        for (int e = 0; e < int'(N_ELEM); e++) begin
            for (int p = 0; p < int'(K); p++) begin
                addr[e][p] = pick_src(sels[(e*int'(K)+p)*int'(SEL_W) +: SEL_W], clu_in, fb);
            end
            row[e]   = tables[e*int'(LUT_SZ) +: LUT_SZ];
            lut_o[e] = row[e][addr[e]];
        end
    end
endmodule

// File: rtl/logic_cluster.sv
`timescale 1ns/1ps
module logic_cluster
    import cluster_pkg::*;
#(
    parameter int unsigned N_ELEM = CL_ELEMS,
    parameter int unsigned K      = CL_LUT_K,
    parameter int unsigned N_IN   = CL_INPUTS,
    parameter int unsigned SEL_W  = CL_SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              cfg_in,
    output logic              cfg_out,
    input  logic [N_IN-1:0]   clu_in,
    output logic [N_ELEM-1:0] clu_out
);
    localparam int unsigned LUT_SZ   = 1 << K;
    localparam int unsigned LUT_BITS = N_ELEM * LUT_SZ;
    localparam int unsigned SEL_BITS = N_ELEM * K * SEL_W;
    localparam int unsigned CFG_LEN  = LUT_BITS + SEL_BITS + N_ELEM;

    typedef struct packed {
        logic [N_ELEM-1:0] ff;
    } state_t;

    state_t st_d, st_q;

    logic [CFG_LEN-1:0]  cfg_bits;
    logic [LUT_BITS-1:0] tables;
    logic [SEL_BITS-1:0] sels;
    logic [N_ELEM-1:0]   mode;
    logic [N_ELEM-1:0]   reg_view;
    logic [N_ELEM-1:0]   lut_final;
    logic [N_ELEM-1:0]   elem_out;
    logic [N_ELEM-1:0]   ff_q;

    cluster_cfg_chain #(.LEN(CFG_LEN)) u_chain (
        .clk     (clk),
        .cfg_en  (cfg_en),
        .cfg_in  (cfg_in),
        .cfg_out (cfg_out),
        .cfg_bits(cfg_bits)
    );

    assign tables = cfg_bits[LUT_BITS-1:0];
    assign sels   = cfg_bits[LUT_BITS +: SEL_BITS];
    assign mode   = cfg_bits[LUT_BITS+SEL_BITS +: N_ELEM];

    // registered elements are known from the start; combinational ones begin at 0
    assign reg_view = mode & st_q.ff;

    // N_ELEM passes settle any register-broken network of depth up to N_ELEM
    for (genvar j = 0; j < int'(N_ELEM); j++) begin : g_pass
        logic [N_ELEM-1:0] fb_in;
        logic [N_ELEM-1:0] lut_o;
        logic [N_ELEM-1:0] fb_out;

        if (j == 0) begin : g_first
            assign fb_in = reg_view;
        end else begin : g_next
            assign fb_in = g_pass[j-1].fb_out;
        end

        cluster_pass #(
            .N_ELEM(N_ELEM),
            .K     (K),
            .N_IN  (N_IN),
            .SEL_W (SEL_W)
        ) u_pass (
            .clu_in(clu_in),
            .fb    (fb_in),
            .tables(tables),
            .sels  (sels),
            .lut_o (lut_o)
        );

        assign fb_out = reg_view | (~mode & lut_o);
    end

    assign lut_final = g_pass[N_ELEM-1].lut_o;
    assign elem_out  = g_pass[N_ELEM-1].fb_out;

    always_comb begin
        st_d = st_q;
        if (rst || cfg_en) begin
            st_d.ff = '0;
        end else begin
            st_d.ff = lut_final;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ff_q    = st_q.ff;
    assign clu_out = cfg_en ? '0 : elem_out;
endmodule

// File: rtl/cluster_chk.sv
`timescale 1ns/1ps
module cluster_chk #(
    parameter int unsigned N_ELEM = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_en,
    input logic              cfg_out,
    input logic [N_ELEM-1:0] clu_out,
    input logic [N_ELEM-1:0] lut_final,
    input logic [N_ELEM-1:0] mode,
    input logic [N_ELEM-1:0] ff_q
);
    AST_RST_CLEARS_FF: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ff_q == '0); // R7

    AST_RST_KEEPS_CFG: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !$past(cfg_en)) |-> $stable(cfg_out)); // R7

    AST_CFG_CLEARS_FF: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_en) |-> ff_q == '0); // R6

    AST_CHAIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(cfg_out)); // R1

    AST_REG_OUT_TIMING: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !$past(cfg_en) && !$past(rst))
        |-> ((clu_out ^ $past(lut_final)) & mode) == '0); // R4
endmodule

bind logic_cluster cluster_chk #(.N_ELEM(N_ELEM)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_en   (cfg_en),
    .cfg_out  (cfg_out),
    .clu_out  (clu_out),
    .lut_final(lut_final),
    .mode     (mode),
    .ff_q     (ff_q)
);

// File: tb/logic_cluster_tb.sv
`timescale 1ns/1ps
module logic_cluster_tb;
    localparam int NE = 10;
    localparam int NI = 40;
    localparam int CFG_LEN = 1010;

    logic clk = 1'b0;
    logic rst, cfg_en, cfg_in, cfg_out;
    logic [NI-1:0] clu_in;
    logic [NE-1:0] clu_out;

    int compared = 0;
    int mismatched = 0;

    always #2 clk = ~clk; // 250 MHz

    logic_cluster u_dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_in(cfg_in),
        .cfg_out(cfg_out), .clu_in(clu_in), .clu_out(clu_out)
    );

    // behavioural description of the loaded functions
    bit [63:0] tt [NE];
    int        sel [NE][6];
    bit        md [NE];
    logic [NE-1:0] mff;
    logic [CFG_LEN-1:0] img, old_img, rb;

    function automatic logic [CFG_LEN-1:0] pack_cfg();
        logic [CFG_LEN-1:0] v;
        v = '0;
        for (int e = 0; e < NE; e++) begin
            v[e*64 +: 64] = tt[e];                               // R2
            for (int p = 0; p < 6; p++) v[640 + (e*6+p)*6 +: 6] = 6'(sel[e][p]); // R3
            v[1000+e] = md[e];                                   // R4
        end
        return v;
    endfunction

    function automatic logic src_val(int code, logic [NI-1:0] din, logic [NE-1:0] cur);
        if (code < 40) return din[code];
        if (code < 50) return cur[code-40];
        return 1'b0;
    endfunction

    task automatic model_eval(input logic [NI-1:0] din, output logic [NE-1:0] outv,
                              output logic [NE-1:0] lutv);
        logic [NE-1:0] cur, nxt, l;
        logic [5:0] a;
        bit done;
        for (int e = 0; e < NE; e++) cur[e] = md[e] ? mff[e] : 1'b0;
        done = 0;
        l = '0;
        for (int it = 0; it < 40; it++) begin
            if (!done) begin
                for (int e = 0; e < NE; e++) begin
                    for (int p = 0; p < 6; p++) a[p] = src_val(sel[e][p], din, cur);
                    l[e] = tt[e][a];
                    nxt[e] = md[e] ? mff[e] : l[e];
                end
                if (nxt == cur) done = 1;
                cur = nxt;
            end
        end
        outv = cur;
        lutv = l;
    endtask

    task automatic setup_cfg1();
        logic [5:0] av;
        bit lower;
        for (int e = 0; e < NE; e++) begin
            md[e] = 0; tt[e] = '0;
            for (int p = 0; p < 6; p++) sel[e][p] = 50 + ((e + p) % 14);
        end
        // 4-bit counter with enable on clu_in[0], elements 0..3 registered
        for (int e = 0; e < 4; e++) begin
            md[e] = 1;
            for (int p = 0; p <= e; p++) sel[e][p] = 40 + p;
            sel[e][5] = 0;
            for (int a = 0; a < 64; a++) begin
                av = 6'(a); lower = 1;
                for (int j = 0; j < e; j++) lower = lower & av[j];
                tt[e][a] = av[e] ^ (av[5] & lower);
            end
        end
        sel[4][0] = 15; sel[4][1] = 12; sel[4][2] = 10;
        sel[4][3] = 14; sel[4][4] = 11; sel[4][5] = 13;
        md[5] = 1; sel[5][2] = 44;
        sel[6][0] = 47; sel[6][3] = 39;
        sel[7][1] = 43; sel[7][4] = 20;
        md[8] = 1; sel[8][0] = 48; sel[8][1] = 30; sel[8][2] = 31;
        sel[9][0] = 1; sel[9][1] = 2; sel[9][2] = 46;
        for (int a = 0; a < 64; a++) begin
            av = 6'(a);
            tt[4][a] = ^av;
            tt[5][a] = av[2];
            tt[6][a] = av[0] & av[3];
            tt[7][a] = av[1] ^ av[4];
            tt[8][a] = av[1] ? av[2] : ~av[0];
            tt[9][a] = (av[0] & av[1]) | (av[0] & av[2]) | (av[1] & av[2]);
        end
        img = pack_cfg();
    endtask

    // ten-deep combinational chain, element 9 first, element 0 last
    task automatic setup_cfg2();
        logic [5:0] av;
        for (int e = 0; e < NE; e++) begin
            md[e] = 0;
            sel[e][0] = (e == 9) ? 0 : 40 + e + 1;
            sel[e][1] = (e == 9) ? 1 : 10 + e;
            for (int p = 2; p < 6; p++) sel[e][p] = 50 + ((e + p) % 14);
            for (int a = 0; a < 64; a++) begin
                av = 6'(a);
                tt[e][a] = ^av;
            end
        end
        img = pack_cfg();
    endtask

    task automatic load(input bit check_rb);
        for (int k = 0; k < CFG_LEN; k++) begin
            @(negedge clk);
            rst = 1'b0; cfg_en = 1'b1; cfg_in = img[k];
            #1;
            compared++;
            if (clu_out !== '0) begin
                mismatched++;
                $display("FAIL R6 shift %0d: clu_out=%b expected %b", k, clu_out, 10'b0);
            end
            rb[k] = cfg_out;
        end
        if (check_rb) begin
            compared++;
            if (rb !== old_img) begin
                mismatched++;
                $display("FAIL R1 readback: got %h expected %h", rb, old_img);
            end
        end
        old_img = img;
        mff = '0; // R6: flip-flops cleared by loading
    endtask

    task automatic run_cycle(input bit do_rst);
        logic [NE-1:0] outv, lutv;
        logic [NI-1:0] din;
        @(negedge clk);
        cfg_en = 1'b0; rst = do_rst;
        din = {8'($urandom), 32'($urandom)};
        clu_in = din;
        #1;
        model_eval(din, outv, lutv);
        compared++;
        if (clu_out !== outv) begin
            mismatched++;
            $display("FAIL R2 R3 R4 R5 R8 R9 t=%0t: clu_out=%b expected %b", $time, clu_out, outv);
        end
        @(posedge clk);
        mff = do_rst ? '0 : lutv; // R7 clears, R5 captures
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_en = 1'b0; cfg_in = 1'b0; clu_in = '0; mff = '0;
        old_img = '0;
        repeat (3) @(posedge clk);
        setup_cfg1();
        load(1'b0);                                  // R6 reset-state outputs
        for (int i = 0; i < 40; i++) run_cycle(1'b0); // R9 counter, R4 modes
        run_cycle(1'b1);                              // R7 reset mid-run
        for (int i = 0; i < 30; i++) run_cycle(1'b0); // R7 functions kept
        setup_cfg2();
        load(1'b1);                                   // R1 readback of first image
        for (int i = 0; i < 40; i++) run_cycle(1'b0); // R8 ten-deep chain, R3 zero codes
        setup_cfg1();
        load(1'b1);                                   // R1 readback, R6 clear
        for (int i = 0; i < 30; i++) run_cycle(1'b0);
        summary();
        $finish;
    end
endmodule